// File: doc/BRIEF.md
# Debug Breakpoint and Entry-Cause Unit

This block watches a processor's data accesses and instruction fetches and raises a breakpoint event when one of them hits a programmed breakpoint. Two data-address registers are compared against each load or store address. The comparison can work in two ways. In normal mode each register is its own word-granular comparator. In mask mode the second register becomes an inverted mask: each of its set bits marks a don't-care bit of the first register's address.

A set of instruction-address registers is compared against the fetch PC. A breakpoint instruction signalled by the core is also accepted as an event, but only while global debug is enabled.

The block holds a debug status register. Bit 31 is the global debug enable, and bits [4:2] record the cause of the last debug entry. Software programs every register through one write port. When several events land in the same cycle, a priority encoder keeps only one of them. The result is a one-cycle pulse together with a cause code.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, bkpt_pulse and bkpt_cause are 0 and dbg_status reads 0. Every breakpoint register is cleared, so no breakpoint is armed.
- R2: A write with reg_wr_en high loads reg_wr_data into the register picked by reg_wr_sel, and the new value is used from the next cycle on. The select codes are: 0 data address A, 1 data address B (or mask), 2 data control, 3 debug status, 4 and 5 instruction breakpoints 0 and 1. Codes 6 and 7 are ignored. The debug status register appears on dbg_status.
- R3: In the data control register, bits [1:0] set the access type for comparator A and bits [3:2] set it for comparator B. The encoding is: 0 off, 1 stores only, 2 loads and stores, 3 loads only. A load is an access with acc_store low.
- R4: In normal mode (control bit 8 clear), a valid access hits comparator A or B when acc_addr[31:2] equals that register's bits [31:2] and the access type is allowed. Address bits [1:0] are ignored.
- R5: In mask mode (control bit 8 set), only the access type in bits [1:0] counts. A valid access hits when (acc_addr AND NOT B) equals (A AND NOT B) across all 32 bits. The bits [3:2] are then ignored.
- R6: Instruction breakpoint k hits when pc_valid is high, bit 0 of its register is 1, and pc[31:2] equals the register's bits [31:2].
- R7: bkpt_insn raises an event only while dbg_status bit 31 is 1. While that bit is 0, it has no effect on any output.
- R8: Cause codes are 1 for an instruction breakpoint, 2 for a data breakpoint and 3 for a breakpoint instruction. When several events occur in the same cycle, the instruction breakpoint wins over the data breakpoint, which wins over the breakpoint instruction.
- R9: An event in cycle n drives bkpt_pulse high for exactly cycle n+1, with bkpt_cause holding the winning code. Instruction and data breakpoint hits pulse whether or not bit 31 is set. With no event, bkpt_pulse is 0 and bkpt_cause is 0.
- R10: When an event occurs while dbg_status bit 31 is 1, dbg_status bits [4:2] take the winning code on the next cycle, and the other bits are unchanged. When bit 31 is 0, events leave dbg_status unchanged. If a status write lands in the same cycle as a recorded event, the written value is taken, but its bits [4:2] are replaced by the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select code |
| reg_wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | ADDR_W | Data access address |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| pc_valid | input | 1 | A fetch PC is presented this cycle |
| pc | input | ADDR_W | Fetch PC |
| bkpt_insn | input | 1 | The core is executing a breakpoint instruction |
| bkpt_pulse | output | 1 | One-cycle breakpoint event |
| bkpt_cause | output | 3 | Cause code of the event, 0 when idle |
| dbg_status | output | 32 | Debug status register |

## Verification
The data comparators are tried against each access-type encoding with both loads and stores, so that a swapped type decode shows up. They are also tried with addresses that differ only in bits [1:0] against addresses that differ in bit 2, which shows whether the word-granular compare is right. Mask mode is tried with one address inside the don't-care window and one outside it. It is also tried with only comparator B's type enabled, which shows whether the wrong enable field is used. Same-cycle combinations of instruction hits, data hits and breakpoint instructions, with the global enable both set and clear, separate the priority order from the cause-recording gate. A long random run with addresses drawn near the programmed registers then compares every output, every cycle, against a behavioural model.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

  localparam int DATA_W       = 32;
  localparam int SEL_W        = 3;
  localparam int MAX_IBP      = 2 ** SEL_W - 4;

  // Control register field positions (decoded by the comparators)
  localparam int CTL_TYPE_A_LSB = 0;
  localparam int CTL_TYPE_B_LSB = 2;
  localparam int CTL_MASK_BIT   = 8;

  // Status register field positions
  localparam int STAT_GDE_BIT = 31;
  localparam int MOE_LSB      = 2;
  localparam int MOE_W        = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DADDR_A   = 3'd0,
    SEL_DADDR_B   = 3'd1,
    SEL_DCTRL     = 3'd2,
    SEL_STATUS    = 3'd3,
    SEL_IADDR_BASE = 3'd4
  } reg_sel_e;

  typedef enum logic [MOE_W-1:0] {
    ENTRY_NONE = 3'd0,
    ENTRY_IBP  = 3'd1,
    ENTRY_DBP  = 3'd2,
    ENTRY_BKPT = 3'd3
  } entry_e;

  typedef enum logic [1:0] {
    ACC_OFF  = 2'd0,
    ACC_ST   = 2'd1,
    ACC_LDST = 2'd2,
    ACC_LD   = 2'd3
  } acc_type_e;

  function automatic logic acc_allowed(input logic [1:0] type_sel, input logic is_store);
    logic ok;
    case (type_sel)
      ACC_ST:   ok = is_store;
      ACC_LDST: ok = 1'b1;
      ACC_LD:   ok = !is_store;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_IBP = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         moe_set,
  input  logic [MOE_W-1:0]             moe_code,
  output logic [ADDR_W-1:0]            daddr_a,
  output logic [ADDR_W-1:0]            daddr_b,
  output logic [1:0]                   type_a,
  output logic [1:0]                   type_b,
  output logic                         mask_mode,
  output logic [NUM_IBP-1:0]           iaddr_en,
  output logic [NUM_IBP-1:0][ADDR_W-3:0] iaddr_word,
  output logic [DATA_W-1:0]            status
);

  // Data address A
  logic              da_we;
  logic [ADDR_W-1:0] da_q;
  assign da_we = wr_en && (wr_sel == SEL_DADDR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     da_q <= '0;
    else if (da_we) da_q <= wr_data[ADDR_W-1:0];
  end

  // Data address B / inverted mask
  logic              db_we;
  logic [ADDR_W-1:0] db_q;
  assign db_we = wr_en && (wr_sel == SEL_DADDR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     db_q <= '0;
    else if (db_we) db_q <= wr_data[ADDR_W-1:0];
  end

  // Data control: only the decoded fields are kept
  logic       ctl_we;
  logic [1:0] ta_q, tb_q;
  logic       mask_q;
  assign ctl_we = wr_en && (wr_sel == SEL_DCTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q   <= '0;
      tb_q   <= '0;
      mask_q <= 1'b0;
    end else if (ctl_we) begin
      ta_q   <= wr_data[CTL_TYPE_A_LSB +: 2];
      tb_q   <= wr_data[CTL_TYPE_B_LSB +: 2];
      mask_q <= wr_data[CTL_MASK_BIT];
    end
  end

  // Instruction breakpoint registers
  for (genvar i = 0; i < NUM_IBP; i++) begin : g_ibp
    logic              ib_we;
    logic              ib_en_q;
    logic [ADDR_W-3:0] ib_word_q;
    assign ib_we = wr_en && (wr_sel == SEL_W'(int'(SEL_IADDR_BASE) + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ib_en_q   <= 1'b0;
        ib_word_q <= '0;
      end else if (ib_we) begin
        ib_en_q   <= wr_data[0];
        ib_word_q <= wr_data[ADDR_W-1:2];
      end
    end

    assign iaddr_en[i]   = ib_en_q;
    assign iaddr_word[i] = ib_word_q;
  end

  // Debug status: next-state and register kept apart
  logic              st_wr;
  logic              st_ce;
  logic [DATA_W-1:0] st_d, st_q;
  assign st_wr = wr_en && (wr_sel == SEL_STATUS);
  assign st_ce = st_wr || moe_set;

  always_comb begin
    st_d = st_q;
    if (st_wr)   st_d = wr_data;
    if (moe_set) st_d[MOE_LSB +: MOE_W] = moe_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_ce) st_q <= st_d;
  end

  assign daddr_a   = da_q;
  assign daddr_b   = db_q;
  assign type_a    = ta_q;
  assign type_b    = tb_q;
  assign mask_mode = mask_q;
  assign status    = st_q;

endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] daddr_a,
  input  logic [ADDR_W-1:0] daddr_b,
  input  logic [1:0]        type_a,
  input  logic [1:0]        type_b,
  input  logic              mask_mode,
  output logic              data_hit
);

  localparam int NUM_CMP = 2;

  logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_addr;
  logic [NUM_CMP-1:0][1:0]        cmp_type;
  logic [NUM_CMP-1:0]             word_hit;

  assign cmp_addr[0] = daddr_a;
  assign cmp_addr[1] = daddr_b;
  assign cmp_type[0] = type_a;
  assign cmp_type[1] = type_b;

  // Word-granular comparators used in normal mode
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_word
    assign word_hit[k] = acc_allowed(cmp_type[k], acc_store) &&
                         (acc_addr[ADDR_W-1:2] == cmp_addr[k][ADDR_W-1:2]);
  end

  // Masked compare: B marks don't-care bits
  logic              masked_hit;
  logic [ADDR_W-1:0] diff;
  assign diff       = (acc_addr ^ daddr_a) & ~daddr_b;
  assign masked_hit = acc_allowed(type_a, acc_store) && (diff == '0);

  always_comb begin
    data_hit = 1'b0;
    if (acc_valid) begin
      if (mask_mode) data_hit = masked_hit;
      else           data_hit = |word_hit;
    end
  end

endmodule

// File: rtl/dbg_insn_cmp.sv
module dbg_insn_cmp #(
  parameter int ADDR_W  = 32,
  parameter int NUM_IBP = 2
) (
  input  logic                           pc_valid,
  input  logic [ADDR_W-1:0]              pc,
  input  logic [NUM_IBP-1:0]             iaddr_en,
  input  logic [NUM_IBP-1:0][ADDR_W-3:0] iaddr_word,
  output logic                           insn_hit
);

  logic [NUM_IBP-1:0] slot_hit;

  for (genvar i = 0; i < NUM_IBP; i++) begin : g_slot
    assign slot_hit[i] = iaddr_en[i] && (pc[ADDR_W-1:2] == iaddr_word[i]);
  end

  logic unused_pc_lo;
  assign unused_pc_lo = ^pc[1:0];

  assign insn_hit = pc_valid && (|slot_hit);

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_hit,
  input  logic             data_hit,
  input  logic             bkpt_insn,
  input  logic             dbg_enable,
  output logic             moe_set,
  output logic [MOE_W-1:0] moe_code,
  output logic             pulse,
  output logic [MOE_W-1:0] cause
);

  entry_e entry_d;

  always_comb begin
    entry_d = ENTRY_NONE;
    if (insn_hit)                      entry_d = ENTRY_IBP;
    else if (data_hit)                 entry_d = ENTRY_DBP;
    else if (bkpt_insn && dbg_enable)  entry_d = ENTRY_BKPT;
  end

  logic event_d;
  assign event_d  = (entry_d != ENTRY_NONE);
  assign moe_set  = event_d && dbg_enable;
  assign moe_code = entry_d;

  logic             pulse_q;
  logic [MOE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      cause_q <= '0;
    end else begin
      pulse_q <= event_d;
      cause_q <= entry_d;
    end
  end

  assign pulse = pulse_q;
  assign cause = cause_q;

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_IBP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              bkpt_insn,
  output logic              bkpt_pulse,
  output logic [2:0]        bkpt_cause,
  output logic [31:0]       dbg_status
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [ADDR_W-1:0]            daddr_a, daddr_b;
  logic [1:0]                   type_a, type_b;
  logic                         mask_mode;
  logic [NUM_IBP-1:0]           iaddr_en;
  logic [NUM_IBP-1:0][ADDR_W-3:0] iaddr_word;
  logic [DATA_W-1:0]            status;
  logic                         moe_set;
  logic [MOE_W-1:0]             moe_code;
  logic                         insn_hit;
  logic                         data_hit;

  dbg_bkpt_regs #(
    .ADDR_W  (ADDR_W),
    .NUM_IBP (NUM_IBP)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_wr_sel),
    .wr_data    (reg_wr_data),
    .moe_set    (moe_set),
    .moe_code   (moe_code),
    .daddr_a    (daddr_a),
    .daddr_b    (daddr_b),
    .type_a     (type_a),
    .type_b     (type_b),
    .mask_mode  (mask_mode),
    .iaddr_en   (iaddr_en),
    .iaddr_word (iaddr_word),
    .status     (status)
  );

  dbg_data_cmp #(
    .ADDR_W (ADDR_W)
  ) u_data_cmp (
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_store (acc_store),
    .daddr_a   (daddr_a),
    .daddr_b   (daddr_b),
    .type_a    (type_a),
    .type_b    (type_b),
    .mask_mode (mask_mode),
    .data_hit  (data_hit)
  );

  dbg_insn_cmp #(
    .ADDR_W  (ADDR_W),
    .NUM_IBP (NUM_IBP)
  ) u_insn_cmp (
    .pc_valid   (pc_valid),
    .pc         (pc),
    .iaddr_en   (iaddr_en),
    .iaddr_word (iaddr_word),
    .insn_hit   (insn_hit)
  );

  dbg_entry_ctrl u_entry (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .insn_hit   (insn_hit),
    .data_hit   (data_hit),
    .bkpt_insn  (bkpt_insn),
    .dbg_enable (status[STAT_GDE_BIT]),
    .moe_set    (moe_set),
    .moe_code   (moe_code),
    .pulse      (bkpt_pulse),
    .cause      (bkpt_cause)
  );

  assign dbg_status = status;

endmodule

// File: rtl/dbg_bkpt_unit_chk.sv
module dbg_bkpt_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic        insn_hit,
  input logic        data_hit,
  input logic        bkpt_insn,
  input logic        bkpt_pulse,
  input logic [2:0]  bkpt_cause,
  input logic [31:0] dbg_status
);

  // R9
  quiet_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_hit || data_hit || bkpt_insn) |=> !bkpt_pulse && (bkpt_cause == 3'd0));

  // R8
  ibp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_hit |=> bkpt_pulse && (bkpt_cause == 3'd1));

  // R8
  dbp_over_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !insn_hit) |=> bkpt_pulse && (bkpt_cause == 3'd2));

  // R7
  bkpt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_insn && !dbg_status[31] && !insn_hit && !data_hit) |=> !bkpt_pulse);

  // R10
  moe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_status[31] && !reg_wr_en) |=> $stable(dbg_status));

  // R10
  moe_ibp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_status[31] && insn_hit) |=> (dbg_status[4:2] == 3'd1));

endmodule

bind dbg_bkpt_unit dbg_bkpt_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .insn_hit   (insn_hit),
  .data_hit   (data_hit),
  .bkpt_insn  (bkpt_insn),
  .bkpt_pulse (bkpt_pulse),
  .bkpt_cause (bkpt_cause),
  .dbg_status (dbg_status)
);

// File: tb/dbg_bkpt_unit_test.sv
module dbg_bkpt_unit_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        acc_store;
  logic        pc_valid;
  logic [31:0] pc;
  logic        bkpt_insn;
  logic        bkpt_pulse;
  logic [2:0]  bkpt_cause;
  logic [31:0] dbg_status;

  int checks = 0;
  int errors = 0;

  dbg_bkpt_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .acc_store   (acc_store),
    .pc_valid    (pc_valid),
    .pc          (pc),
    .bkpt_insn   (bkpt_insn),
    .bkpt_pulse  (bkpt_pulse),
    .bkpt_cause  (bkpt_cause),
    .dbg_status  (dbg_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference state
  logic [31:0] m_reg [0:7];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit allow(input int t, input bit st);
    return (t == 2) || (t == 1 && st) || (t == 3 && !st);
  endfunction

  // One clock: drive, predict, wait, compare every output with the model
  task automatic step(input bit we, input int sel, input logic [31:0] wd,
                      input bit av, input logic [31:0] aa, input bit st,
                      input bit pv, input logic [31:0] pcx, input bit bi);
    bit ib, db, bt;
    int code;
    logic [31:0] ns;
    reg_wr_en = we; reg_wr_sel = sel[2:0]; reg_wr_data = wd;
    acc_valid = av; acc_addr = aa; acc_store = st;
    pc_valid = pv; pc = pcx; bkpt_insn = bi;
    ib = 0;
    for (int i = 0; i < 2; i++)
      if (pv && m_reg[4+i][0] && pcx[31:2] == m_reg[4+i][31:2]) ib = 1;
    db = 0;
    if (av) begin
      if (m_reg[2][8])
        db = allow(int'(m_reg[2][1:0]), st) && ((aa & ~m_reg[1]) == (m_reg[0] & ~m_reg[1]));
      else
        db = (allow(int'(m_reg[2][1:0]), st) && aa[31:2] == m_reg[0][31:2]) ||
             (allow(int'(m_reg[2][3:2]), st) && aa[31:2] == m_reg[1][31:2]);
    end
    bt = bi && m_reg[3][31];
    code = ib ? 1 : db ? 2 : bt ? 3 : 0;
    ns = (we && sel == 3) ? wd : m_reg[3];
    if (code != 0 && m_reg[3][31]) ns[4:2] = code[2:0];
    if (we && sel <= 5) m_reg[sel] = wd;
    m_reg[3] = ns;
    @(negedge clk);
    chk("R9 pulse", {31'd0, bkpt_pulse}, {31'd0, code != 0});
    chk("R8 cause", {29'd0, bkpt_cause}, code);
    chk("R10 status", dbg_status, ns);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    step(1, sel, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(input logic [31:0] a, input bit st);
    step(0, 0, 0, 1, a, st, 0, 0, 0);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    rst_n = 1'b0;
    reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0;
    acc_valid = 0; acc_addr = 0; acc_store = 0;
    pc_valid = 0; pc = 0; bkpt_insn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pulse", {31'd0, bkpt_pulse}, 0);
    chk("R1 cause", {29'd0, bkpt_cause}, 0);
    chk("R1 status", dbg_status, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: status write visible; code 7 ignored
    wr(3, 32'h8000_0000);
    chk("R2 status write", dbg_status, 32'h8000_0000);
    wr(7, 32'hFFFF_FFFF);
    chk("R2 unused select", dbg_status, 32'h8000_0000);

    // R3/R4: comparator A stores only
    wr(0, 32'h1000_0010);
    wr(2, 32'h0000_0001);
    acc(32'h1000_0012, 0);
    chk("R3 load vs store-only", {31'd0, bkpt_pulse}, 0);
    acc(32'h1000_0013, 1);
    chk("R4 low bits ignored", {29'd0, bkpt_cause}, 2);
    chk("R10 moe data", dbg_status, 32'h8000_0008);
    idle();
    chk("R9 single pulse", {31'd0, bkpt_pulse}, 0);
    acc(32'h1000_0014, 1);
    chk("R4 bit2 differs", {31'd0, bkpt_pulse}, 0);

    // R3: loads only on A, both on B
    wr(1, 32'h2000_0000);
    wr(2, 32'h0000_000B);
    acc(32'h1000_0010, 1);
    chk("R3 store vs load-only", {31'd0, bkpt_pulse}, 0);
    acc(32'h1000_0010, 0);
    chk("R3 load-only hit", {31'd0, bkpt_pulse}, 1);
    acc(32'h2000_0001, 1);
    chk("R3 comparator B store", {31'd0, bkpt_pulse}, 1);

    // R5: mask mode
    wr(0, 32'h3000_0000);
    wr(1, 32'h0000_00FF);
    wr(2, 32'h0000_0102);
    acc(32'h3000_00AB, 0);
    chk("R5 inside mask", {31'd0, bkpt_pulse}, 1);
    acc(32'h3000_0100, 0);
    chk("R5 outside mask", {31'd0, bkpt_pulse}, 0);
    wr(2, 32'h0000_0108);
    acc(32'h3000_0000, 0);
    chk("R5 type B ignored", {31'd0, bkpt_pulse}, 0);

    // R6: instruction breakpoints
    wr(4, 32'h4000_0001);
    wr(5, 32'h5000_0000);
    step(0, 0, 0, 0, 0, 0, 1, 32'h4000_0002, 0);
    chk("R6 ibp hit", {29'd0, bkpt_cause}, 1);
    chk("R10 moe ibp", dbg_status[4:2], 1);
    step(0, 0, 0, 0, 0, 0, 1, 32'h5000_0000, 0);
    chk("R6 disabled slot", {31'd0, bkpt_pulse}, 0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h4000_0000, 0);
    chk("R6 pc_valid low", {31'd0, bkpt_pulse}, 0);

    // R7: breakpoint instruction
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 bkpt enabled", {29'd0, bkpt_cause}, 3);
    chk("R10 moe bkpt", dbg_status, 32'h8000_000C);
    wr(3, 32'h0000_0000);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 bkpt ignored", {31'd0, bkpt_pulse}, 0);
    chk("R7 status untouched", dbg_status, 0);

    // R8/R10: priority; recording gated by enable
    wr(2, 32'h0000_0002);
    wr(0, 32'h6000_0000);
    step(0, 0, 0, 1, 32'h6000_0000, 0, 1, 32'h4000_0000, 1);
    chk("R8 ibp first", {29'd0, bkpt_cause}, 1);
    chk("R10 no record when disabled", dbg_status, 0);
    wr(3, 32'h8000_0000);
    step(0, 0, 0, 1, 32'h6000_0000, 1, 0, 0, 1);
    chk("R8 dbp over bkpt", {29'd0, bkpt_cause}, 2);
    step(1, 3, 32'h8000_0010, 1, 32'h6000_0000, 1, 0, 0, 0);
    chk("R10 write merged", dbg_status, 32'h8000_0008);

    // Random run against the model
    for (int n = 0; n < 3000; n++) begin
      int r, sel;
      logic [31:0] d, a, p;
      r = $urandom_range(0, 9);
      sel = $urandom_range(0, 7);
      d = $urandom;
      if (sel == 2) d = d & 32'h0000_01FF;
      if (sel == 4 || sel == 5) d[0] = $urandom_range(0, 3) != 0;
      a = m_reg[$urandom_range(0, 1)] ^ (32'h1 << $urandom_range(0, 12));
      if ($urandom_range(0, 2) == 0) a = m_reg[$urandom_range(0, 1)];
      p = m_reg[4 + $urandom_range(0, 1)] ^ ($urandom_range(0, 1) ? 32'h0 : (32'h1 << $urandom_range(0, 5)));
      step(r == 0, sel, d, $urandom_range(0, 1), a, $urandom_range(0, 1),
           $urandom_range(0, 1), p, $urandom_range(0, 3) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule